// File: doc/BRIEF.md
# DMA Request and Bus-Mode Sequencer

This block is the control core of a single external-bus DMA channel. It decides when a transfer unit may begin and when the shared bus is requested and given back. It does not generate addresses or move data. Each transfer unit is a fixed-length bus access of `ACC_CYCLES` clocks, and the block marks its first and last cycle with strobes.

A pulse on `en_set` sets the channel's enable bit and takes a snapshot of the configuration inputs. In auto mode the channel makes its own requests. In external mode it waits for the active-low `req_n`, which it senses either as a low level or as a falling edge. Three bus behaviours are offered:
- cycle steal, which gives the bus back after every unit;
- burst, which keeps the bus until the count is used up;
- block, where a single external request runs a whole block of units back to back.

An optional acknowledge pulse confirms that a request has been accepted. When the transfer count reaches zero, the enable bit clears and `done` is set.

Top module: `dma_seq_core`

## Requirements
- R1: After reset `bus_req`=0, `ack_n`=1, `done`=0, `enabled`=0, `unit_start`=0, `unit_done`=0.
- R2: With `req_mode`=0 (auto), an `en_set` pulse with a non-zero `xfer_count` starts units without any activity on `req_n`. Exactly `xfer_count` units run.
- R3: In cycle-steal behaviour, `bus_req` is low for at least one cycle between the `unit_done` of one unit and the `unit_start` of the next.
- R4: In burst behaviour (`req_mode`=0, `bus_mode`=2'b01), `bus_req` stays high from the first unit to the last. The next unit starts in the cycle after each `unit_done`.
- R5: With `req_mode`=1 and `sense_edge`=0, a unit is accepted only while the synchronised `req_n` is low. The level is sampled again before each unit. While `req_n` stays high, `bus_req` stays 0.
- R6: With `req_mode`=1 and `sense_edge`=1, each falling edge of `req_n` seen while enabled is held pending and accepted once. A `req_n` held low gives no further units.
- R7: With `req_mode`=1 and `ack_en`=1, `ack_n` is low for exactly the cycle in which `unit_start` is high for the first unit following an accepted request. It is never low in auto mode or when `ack_en`=0.
- R8: With `req_mode`=1 and `bus_mode`=2'b10 (block), one accepted request runs `blk_size` units with the bus held throughout. The acknowledge is given once per block. A `blk_size` of 0 counts as 1.
- R9: Each `unit_done` decrements the remaining count. When the count reaches zero, `done`=1, `enabled`=0 and `bus_req`=0 in the following cycle.
- R10: Auto with `bus_mode`=2'b10, external with `bus_mode`=2'b01, and any mode with `bus_mode`=2'b11 all behave as cycle steal.
- R11: A unit starts only after `bus_grant` has been sampled high while the bus is requested. `unit_done` follows `unit_start` by exactly `ACC_CYCLES`-1 cycles.
- R12: An `en_set` pulse with `xfer_count`=0 sets `done` in the next cycle and never raises `bus_req`. `en_set` clears `done` otherwise.
- R13: In block behaviour, a block that would run past the remaining count stops when the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | Pulse: set enable bit and capture configuration (ignored while enabled) |
| req_mode | input | 1 | 0 = auto requests, 1 = external requests |
| bus_mode | input | 2 | 00 cycle steal, 01 burst, 10 block, 11 cycle steal |
| sense_edge | input | 1 | 0 = low-level sensing, 1 = falling-edge sensing |
| ack_en | input | 1 | Enable the acknowledge pulse |
| blk_size | input | BLK_W | Units per block |
| xfer_count | input | CNT_W | Total units to transfer |
| req_n | input | 1 | Active-low external transfer request |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_req | output | 1 | Bus request |
| unit_start | output | 1 | First cycle of a transfer unit |
| unit_done | output | 1 | Last cycle of a transfer unit |
| ack_n | output | 1 | Active-low request acknowledge |
| done | output | 1 | Transfer count reached zero |
| enabled | output | 1 | Enable bit |

## Verification
The bench runs the sequencer in seven configurations:
- auto cycle steal, auto burst and auto with block selected, which separate bus release from bus holding and show the mode folding;
- external level, external edge and external with burst selected, which separate re-sampling from one-shot acceptance;
- external block with a partial last block.

For each expected unit, the scoreboard records whether the acknowledge should coincide with it and whether the bus should have stayed held since the previous unit. These two bits are what tell the bus behaviours apart. A withheld grant, a zero count and a request held low in edge mode probe the boundaries.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      EFF_STEAL = 2'd0,
      EFF_BURST = 2'd1,
      EFF_BLOCK = 2'd2
   } eff_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAITQ = 2'd1,
      ST_BREQ  = 2'd2,
      ST_XFER  = 2'd3
   } seq_state_e;

   // Burst is only allowed with auto requests; block only with external ones.
   function automatic eff_mode_e resolve_mode(input logic ext, input logic [1:0] bm);
      if (!ext && bm == 2'b01) return EFF_BURST;
      if (ext && bm == 2'b10)  return EFF_BLOCK;
      return EFF_STEAL;
   endfunction

endpackage

// File: rtl/dma_req_sense.sv
module dma_req_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   input  logic edge_mode,
   input  logic arm,
   input  logic consume,
   output logic req_seen
);

   logic req_s_n;
   logic prev_n;
   logic pend;
   logic fall;

   initial begin
      if (SYNC_STAGES < 0) $error("SYNC_STAGES must not be negative");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign req_s_n = req_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= req_n;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign req_s_n = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign fall = prev_n & ~req_s_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= 1'b1;
         pend   <= 1'b0;
      end else begin
         prev_n <= req_s_n;
         if (!arm) pend <= 1'b0;
         else      pend <= (pend & ~consume) | fall;
      end
   end

   assign req_seen = edge_mode ? pend : ~req_s_n;

   // R6: a pending edge survives until it is consumed
   p_pend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !consume && arm) |=> pend);

endmodule

// File: rtl/dma_unit_timer.sv
module dma_unit_timer #(
   parameter int ACC_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic first,
   output logic last
);

   initial begin
      if (ACC_CYCLES < 1) $error("ACC_CYCLES must be at least 1");
   end

   generate
      if (ACC_CYCLES == 1) begin : g_single
         assign first = run;
         assign last  = run;
      end else begin : g_count
         localparam int TMR_W = $clog2(ACC_CYCLES);
         localparam logic [TMR_W-1:0] LAST_V = TMR_W'(ACC_CYCLES - 1);
         logic [TMR_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt <= '0;
            else if (!run || cnt == LAST_V) cnt <= '0;
            else                            cnt <= cnt + 1'b1;
         end
         assign first = run && (cnt == '0);
         assign last  = run && (cnt == LAST_V);

         // R11: timer never exceeds its access length
         p_tmr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST_V);
         // R11: a running access advances one step per cycle
         p_tmr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (run && cnt != LAST_V) |=> (!run || cnt == $past(cnt) + 1'b1));
      end
   endgenerate

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
   parameter int CNT_W = 16,
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [BLK_W-1:0] load_blk,
   input  logic             blk_restart,
   input  logic             unit_done,
   output logic             last_unit,
   output logic             blk_last
);

   localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);

   logic [CNT_W-1:0] remaining;
   logic [BLK_W-1:0] blk_cfg;
   logic [BLK_W-1:0] blk_left;

   initial begin
      if (CNT_W < 1 || BLK_W < 1) $error("counter widths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         blk_cfg   <= BLK_ONE;
         blk_left  <= BLK_ONE;
      end else begin
         if (load) begin
            remaining <= load_cnt;
            blk_cfg   <= (load_blk == '0) ? BLK_ONE : load_blk;
         end else if (unit_done) begin
            remaining <= remaining - 1'b1;
         end
         if (blk_restart)                     blk_left <= blk_cfg;
         else if (unit_done && blk_left != 0) blk_left <= blk_left - 1'b1;
      end
   end

   assign last_unit = (remaining == CNT_W'(1));
   assign blk_last  = (blk_left <= BLK_ONE);

   // R9: no unit completes with nothing left to transfer
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unit_done |-> remaining != '0);

endmodule

// File: rtl/dma_seq_core.sv
module dma_seq_core
   import dma_seq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BLK_W       = 8,
   parameter int ACC_CYCLES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_set,
   input  logic             req_mode,
   input  logic [1:0]       bus_mode,
   input  logic             sense_edge,
   input  logic             ack_en,
   input  logic [BLK_W-1:0] blk_size,
   input  logic [CNT_W-1:0] xfer_count,
   input  logic             req_n,
   input  logic             bus_grant,
   output logic             bus_req,
   output logic             unit_start,
   output logic             unit_done,
   output logic             ack_n,
   output logic             done,
   output logic             enabled
);

   seq_state_e state, state_nx;
   eff_mode_e  eff_r;
   logic       ext_r, edge_r, ack_en_r;
   logic       ack_arm;
   logic       req_seen, accept, consume, load;
   logic       u_first, u_last, last_unit, blk_last;
   logic       finish;

   assign load    = (state == ST_IDLE) && en_set && (xfer_count != '0);
   assign accept  = (state == ST_WAITQ) && (!ext_r || req_seen);
   assign consume = accept && ext_r && edge_r;
   assign finish  = (state == ST_XFER) && u_last && last_unit;

   dma_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_n    (req_n),
      .edge_mode(edge_r),
      .arm      (enabled),
      .consume  (consume),
      .req_seen (req_seen)
   );

   dma_unit_timer #(.ACC_CYCLES(ACC_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_XFER),
      .first(u_first),
      .last (u_last)
   );

   dma_xfer_ctr #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_cnt   (xfer_count),
      .load_blk   (blk_size),
      .blk_restart(accept),
      .unit_done  (u_last && state == ST_XFER),
      .last_unit  (last_unit),
      .blk_last   (blk_last)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (load) state_nx = ST_WAITQ;
         ST_WAITQ: if (accept) state_nx = ST_BREQ;
         ST_BREQ:  if (bus_grant) state_nx = ST_XFER;
         ST_XFER: begin
            if (u_last) begin
               if (last_unit)                          state_nx = ST_IDLE;
               else if (eff_r == EFF_BURST)            state_nx = ST_XFER;
               else if (eff_r == EFF_BLOCK && !blk_last) state_nx = ST_XFER;
               else                                    state_nx = ST_WAITQ;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         eff_r    <= EFF_STEAL;
         ext_r    <= 1'b0;
         edge_r   <= 1'b0;
         ack_en_r <= 1'b0;
         ack_arm  <= 1'b0;
         done     <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && en_set) begin
            eff_r    <= resolve_mode(req_mode, bus_mode);
            ext_r    <= req_mode;
            edge_r   <= sense_edge;
            ack_en_r <= ack_en;
            done     <= (xfer_count == '0);
         end else if (finish) begin
            done <= 1'b1;
         end
         if (accept && ext_r && ack_en_r) ack_arm <= 1'b1;
         else if (u_first)                ack_arm <= 1'b0;
      end
   end

   assign enabled    = (state != ST_IDLE);
   assign bus_req    = (state == ST_BREQ) || (state == ST_XFER);
   assign unit_start = u_first;
   assign unit_done  = u_last;
   assign ack_n      = ~(ack_arm & u_first);

   // R3: cycle steal gives the bus back after a unit
   p_steal_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && !last_unit && eff_r == EFF_STEAL) |=> !bus_req);
   // R4: burst keeps the bus and starts the next unit at once
   p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && !last_unit && eff_r == EFF_BURST) |=> (bus_req && unit_start));
   // R7: acknowledge is a single-cycle pulse
   p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |=> ack_n);
   // R9: completion leaves the channel disabled and off the bus
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!bus_req && !enabled));
   // R11: a fresh bus request never coincides with a unit start
   p_grant_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !unit_start);

endmodule

// File: tb/sim_dma_seq_core.sv
module sim_dma_seq_core;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int BLK_W = 8;
   localparam int ACC   = 3;

   typedef struct {
      bit    ack;
      bit    cont;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_set = 1'b0, req_mode = 1'b0, sense_edge = 1'b0, ack_en = 1'b0;
   logic [1:0] bus_mode = 2'b00;
   logic [BLK_W-1:0] blk_size = '0;
   logic [CNT_W-1:0] xfer_count = '0;
   logic req_n = 1'b1;
   logic bus_grant = 1'b0;
   logic grant_block = 1'b0;
   logic bus_req, unit_start, unit_done, ack_n, done, enabled;

   int n_chk = 0, n_fail = 0, units = 0, cyc = 0, start_cyc = 0;
   bit held = 1'b0, finished = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_seq_core #(.CNT_W(CNT_W), .BLK_W(BLK_W), .ACC_CYCLES(ACC), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .en_set(en_set), .req_mode(req_mode),
      .bus_mode(bus_mode), .sense_edge(sense_edge), .ack_en(ack_en),
      .blk_size(blk_size), .xfer_count(xfer_count), .req_n(req_n),
      .bus_grant(bus_grant), .bus_req(bus_req), .unit_start(unit_start),
      .unit_done(unit_done), .ack_n(ack_n), .done(done), .enabled(enabled)
   );

   always @(posedge clk) bus_grant <= rst_n && bus_req && !grant_block;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: compare each unit against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!bus_req) held = 1'b0;
         if (unit_start) begin
            units++;
            start_cyc = cyc;
            if (q.size() == 0) begin
               chk(1'b0, "R2 unexpected unit", units, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(ack_n == !e.ack, {e.tag, " ack_n at unit start"}, int'(ack_n), int'(!e.ack));
               chk(held == e.cont, {e.tag, " bus held since previous unit"}, int'(held), int'(e.cont));
            end
         end
         if (unit_done) begin
            chk(cyc - start_cyc == ACC - 1, "R11 unit length", cyc - start_cyc, ACC - 1);
            held = 1'b1;
         end
      end
   end

   task automatic push(input bit ack, input bit cont, input string tag);
      exp_t e;
      e.ack = ack; e.cont = cont; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic run_cfg(input logic md, input logic [1:0] bm, input logic se,
                          input logic ae, input int blk, input int cnt);
      @(negedge clk);
      req_mode = md; bus_mode = bm; sense_edge = se; ack_en = ae;
      blk_size = BLK_W'(blk); xfer_count = CNT_W'(cnt);
      en_set = 1'b1;
      @(negedge clk);
      en_set = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, {req, " done raised"}, int'(done), 1);
      chk(enabled == 1'b0 && bus_req == 1'b0, "R9 disabled and off bus at done",
          int'({enabled, bus_req}), 0);
      chk(q.size() == 0, {req, " all expected units seen"}, q.size(), 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(bus_req == 0 && ack_n == 1 && done == 0, "R1 reset outputs",
          int'({bus_req, ack_n, done}), 3'b010);
      chk(enabled == 0 && unit_start == 0 && unit_done == 0, "R1 reset strobes",
          int'({enabled, unit_start, unit_done}), 0);
      rst_n = 1'b1;
      idle(2);

      // R12: zero count
      run_cfg(1'b0, 2'b00, 1'b0, 1'b0, 1, 0);
      chk(done == 1 && enabled == 0 && bus_req == 0, "R12 zero count completes at once",
          int'({done, enabled, bus_req}), 3'b100);
      idle(5);
      chk(units == 0, "R12 no units for zero count", units, 0);

      // R2 R3 R7: auto cycle steal, ack enabled but unused in auto mode
      for (int i = 0; i < 4; i++) push(1'b0, 1'b0, "R3 auto steal");
      run_cfg(1'b0, 2'b00, 1'b0, 1'b1, 1, 4);
      chk(done == 0, "R12 en_set clears done", int'(done), 0);
      wait_done("R2");

      // R4: auto burst
      push(1'b0, 1'b0, "R4 burst first");
      push(1'b0, 1'b1, "R4 burst");
      push(1'b0, 1'b1, "R4 burst");
      run_cfg(1'b0, 2'b01, 1'b0, 1'b0, 1, 3);
      wait_done("R4");

      // R10: auto with block selected folds to cycle steal
      for (int i = 0; i < 3; i++) push(1'b0, 1'b0, "R10 auto block as steal");
      run_cfg(1'b0, 2'b10, 1'b0, 1'b0, 4, 3);
      wait_done("R10");

      // R11: no unit before the grant
      grant_block = 1'b1;
      base = units;
      run_cfg(1'b0, 2'b00, 1'b0, 1'b0, 1, 1);
      idle(20);
      chk(bus_req == 1, "R11 bus requested while grant withheld", int'(bus_req), 1);
      chk(units == base, "R11 no unit without grant", units - base, 0);
      push(1'b0, 1'b0, "R11 after grant");
      grant_block = 1'b0;
      wait_done("R11");

      // R5 R7: external level sensing with acknowledge
      base = units;
      run_cfg(1'b1, 2'b00, 1'b0, 1'b1, 1, 3);
      idle(20);
      chk(bus_req == 0 && units == base, "R5 no request while req_n high",
          int'(bus_req) + units - base, 0);
      for (int i = 0; i < 3; i++) push(1'b1, 1'b0, "R5 level unit");
      req_n = 1'b0;
      wait_done("R5");
      req_n = 1'b1;
      idle(5);

      // R6: external falling edge, one unit per edge
      base = units;
      push(1'b0, 1'b0, "R6 edge unit");
      run_cfg(1'b1, 2'b00, 1'b1, 1'b0, 1, 3);
      idle(5);
      req_n = 1'b0;
      idle(30);
      chk(units - base == 1, "R6 held low gives one unit", units - base, 1);
      chk(enabled == 1 && bus_req == 0, "R6 waits for next edge",
          int'({enabled, bus_req}), 2'b10);
      for (int k = 0; k < 2; k++) begin
         push(1'b0, 1'b0, "R6 edge unit");
         req_n = 1'b1;
         idle(5);
         req_n = 1'b0;
         idle(30);
      end
      wait_done("R6");
      req_n = 1'b1;
      idle(5);

      // R10: external with burst selected folds to cycle steal
      push(1'b1, 1'b0, "R10 ext burst as steal");
      push(1'b1, 1'b0, "R10 ext burst as steal");
      run_cfg(1'b1, 2'b01, 1'b0, 1'b1, 1, 2);
      req_n = 1'b0;
      wait_done("R10");
      req_n = 1'b1;
      idle(5);

      // R8 R13: block transfer, one edge per block, partial last block
      base = units;
      push(1'b1, 1'b0, "R8 block first");
      push(1'b0, 1'b1, "R8 block");
      push(1'b0, 1'b1, "R8 block");
      run_cfg(1'b1, 2'b10, 1'b1, 1'b1, 3, 5);
      idle(5);
      req_n = 1'b0;
      idle(40);
      chk(units - base == 3, "R8 one request runs one block", units - base, 3);
      chk(enabled == 1 && bus_req == 0, "R8 bus released after block",
          int'({enabled, bus_req}), 2'b10);
      push(1'b1, 1'b0, "R13 partial block first");
      push(1'b0, 1'b1, "R13 partial block");
      req_n = 1'b1;
      idle(5);
      req_n = 1'b0;
      wait_done("R13");
      chk(units - base == 5, "R13 block stops at count zero", units - base, 5);
      req_n = 1'b1;
      idle(10);

      finished = 1'b1;
      summary();
   end

endmodule